// File: doc/BRIEF.md
# Stream-to-Memory Descriptor DMA Writer

This block is the receive side of a linked-list DMA channel. A client pushes bytes over a valid/ready stream that carries an end-of-packet marker. The engine writes those bytes into memory at the buffer described by the current descriptor. A descriptor is closed when its buffer is full or when a packet ends, whichever comes first. On close, the engine does the following in order:

- It rewrites the descriptor's end address so that it points just past the data actually written.
- It records end-of-packet in the descriptor's flags word.
- It raises the raw interrupt bits.
- It writes the descriptor back to memory.
- It then either fetches the next descriptor in the chain or, at end of list, marks the context disabled and parks.

Software starts the channel by giving the engine a first-descriptor address and a context address. All memory traffic uses one 32-bit word master with a request/acknowledge handshake and per-byte enables. Register decode sits outside the block: the start pulse, the interrupt mask and the interrupt clear arrive as plain inputs.

A descriptor is four little-endian words at byte offsets 0, 4, 8 and 12:
- offset 0: the next-descriptor address
- offset 4: the buffer start address
- offset 8: the flags word
- offset 12: the end address, which is exclusive

In the flags word:
- bit 0 marks the last descriptor of the list
- bit 4 requests an interrupt on close
- bit 11 is the input end-of-packet bit, which the engine sets

Top module: `stream_dma_writer`

## Requirements
- R1: While reset is asserted and right after it, `s_ready`, `m_req`, `irq` and `at_eol` are low and `intr_raw` is 0.
- R2: A `start` pulse taken while idle makes the engine fetch the four descriptor words from `start_desc` + 0, 4, 8 and 12. Stream byte i is then written to address buffer-start + i, in byte lane address[1:0] of the 32-bit word (little-endian).
- R3: Only bytes in the range from buffer start up to the final write pointer are modified. Partial words are written with byte enables, so bytes sharing a word with the buffer keep their contents.
- R4: When the write pointer reaches the end address without end-of-packet, the descriptor closes. Its stored end address stays unchanged and its flags bit 11 stays clear.
- R5: A byte carrying `s_last` closes the descriptor at once. The stored end address becomes the address after that byte, flags bit 11 is set, and raw interrupt bit 3 is set. `s_ready` is low in the cycle after that byte.
- R6: A descriptor whose flags bit 4 is set sets raw interrupt bits 0 and 1 when it closes.
- R7: After closing a descriptor whose flags bit 0 is clear, the engine fetches the descriptor at the next-descriptor address and continues filling at that descriptor's buffer start.
- R8: Closing a descriptor whose flags bit 0 is set is followed by one context write of 0x80 into byte 1 of the word at `start_ctx` + 4 (byte enables 0010, setting its bit 15 and leaving its other bytes alone). `at_eol` then rises. A later `start` clears `at_eol`.
- R9: While `at_eol` is high, `s_ready` and `m_req` stay low, and offered stream bytes change nothing in memory.
- R10: `s_ready` is low in every cycle in which a memory request is outstanding (descriptor fetch, data word write, descriptor or context write-back).
- R11: `irq` equals the OR of `intr_raw & intr_mask`. A 1 in `intr_clear` for one cycle clears that raw bit, and raw bits never fall otherwise.
- R12: A descriptor whose buffer start equals its end address closes right after its fetch, with no data write and no stream byte consumed.
- R13: Once raised, `m_req` with its address, direction and byte enables stays unchanged until `m_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start | input | 1 | Start pulse, taken only while idle |
| start_desc | input | AW | Address of the first descriptor |
| start_ctx | input | AW | Address of the context block |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Byte ends a packet |
| s_ready | output | 1 | Engine accepts a byte this cycle |
| m_req | output | 1 | Memory request |
| m_we | output | 1 | 1 = write, 0 = read |
| m_addr | output | AW | Byte address, word aligned |
| m_wdata | output | 32 | Write data |
| m_be | output | 4 | Byte enables for writes |
| m_ack | input | 1 | Request completed; read data valid |
| m_rdata | input | 32 | Read data |
| intr_mask | input | 4 | Interrupt mask |
| intr_clear | input | 4 | Raw interrupt clear, one bit per raw bit |
| intr_raw | output | 4 | Raw interrupt bits |
| irq | output | 1 | Masked interrupt request |
| at_eol | output | 1 | Channel has reached end of list |

## Verification
The bench goes after buffers that start and end mid-word. A design that ignored byte enables would overwrite the neighbouring sentinel bytes, and one that flushed at the wrong point would drop or misplace tail bytes. It closes descriptors both by filling them and by packets ending exactly on or short of the end address. A design that got this wrong would leave a stale end address, miss flags bit 11, or spill the next packet's bytes into the old buffer. Zero-length descriptors and random chains check that the chain advances without consuming data. Offering bytes after end of list shows whether a design keeps accepting data it has nowhere to put.

// File: rtl/s2m_pkg.sv
package s2m_pkg;
  localparam int DW          = 32;
  localparam int NBYTE       = DW / 8;
  localparam int LANE_W      = $clog2(NBYTE);
  localparam int DESC_WORDS  = 4;
  localparam int CNT_W       = $clog2(DESC_WORDS);

  // descriptor word indices
  localparam int W_NEXT  = 0;
  localparam int W_BUF   = 1;
  localparam int W_FLAGS = 2;
  localparam int W_AFTER = 3;

  // flags bits
  localparam int F_EOL    = 0;
  localparam int F_INTR   = 4;
  localparam int F_IN_EOP = 11;

  // context: word holding the disable bit
  localparam int CTX_FLAG_WORD = 1;
  localparam int CTX_DIS_BIT   = 15;

  // raw interrupt layout
  localparam int IRQ_W     = 4;
  localparam int IRQ_DATA0 = 0;
  localparam int IRQ_DATA1 = 1;
  localparam int IRQ_EOP   = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_STREAM,
    ST_FLUSH,
    ST_WB_FLAGS,
    ST_WB_AFTER,
    ST_CTX
  } seq_e;
endpackage

// File: rtl/s2m_pack.sv
module s2m_pack
  import s2m_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              put,
  input  logic [LANE_W-1:0] lane,
  input  logic [7:0]        din,
  input  logic              clr,
  output logic [DW-1:0]     word,
  output logic [NBYTE-1:0]  be
);
  logic [DW-1:0]    word_q, word_d;
  logic [NBYTE-1:0] be_q, be_d, hit;

  for (genvar g = 0; g < NBYTE; g++) begin : g_lane
    assign hit[g]            = put && (lane == LANE_W'(g));
    assign word_d[g*8 +: 8]  = hit[g] ? din : word_q[g*8 +: 8];
    assign be_d[g]           = hit[g] | (be_q[g] & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      be_q   <= '0;
    end else if (put || clr) begin
      word_q <= word_d;
      be_q   <= be_d;
    end
  end

  assign word = word_q;
  assign be   = be_q;
endmodule

// File: rtl/s2m_irq.sv
module s2m_irq
  import s2m_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_intr,
  input  logic             set_eop,
  input  logic [IRQ_W-1:0] clear,
  input  logic [IRQ_W-1:0] mask,
  output logic [IRQ_W-1:0] raw,
  output logic             irq
);
  logic [IRQ_W-1:0] raw_q, raw_d, setv;

  always_comb begin
    setv            = '0;
    setv[IRQ_DATA0] = set_intr;
    setv[IRQ_DATA1] = set_intr;
    setv[IRQ_EOP]   = set_eop;
    raw_d           = (raw_q & ~clear) | setv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

  assign raw = raw_q;
  assign irq = |(raw_q & mask);
endmodule

// File: rtl/s2m_seq.sv
module s2m_seq
  import s2m_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     start_desc,
  input  logic [AW-1:0]     start_ctx,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  output logic              pack_put,
  output logic [LANE_W-1:0] pack_lane,
  output logic              pack_clr,
  input  logic [DW-1:0]     pack_word,
  input  logic [NBYTE-1:0]  pack_be,
  output logic              m_req,
  output logic              m_we,
  output logic [AW-1:0]     m_addr,
  output logic [DW-1:0]     m_wdata,
  output logic [NBYTE-1:0]  m_be,
  input  logic              m_ack,
  input  logic [DW-1:0]     m_rdata,
  output logic              set_intr,
  output logic              set_eop,
  output logic              at_eol
);
  seq_e             state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [AW-1:0]    desc_q, desc_d, ctx_q, ctx_d, next_q, next_d;
  logic [AW-1:0]    ptr_q, ptr_d, after_q, after_d, waddr_q, waddr_d;
  logic [DW-1:0]    flags_q, flags_d;
  logic             eop_q, eop_d, close_q, close_d, eol_q, eol_d;
  logic             xfer, accept, full;
  logic [AW-1:0]    ptr_inc, rd_addr;

  assign xfer    = m_req & m_ack;
  assign s_ready = (state_q == ST_STREAM);
  assign accept  = s_valid & s_ready;
  assign ptr_inc = ptr_q + AW'(1);
  assign full    = (ptr_inc == after_q);
  assign rd_addr = AW'(m_rdata);

  assign pack_put  = accept;
  assign pack_lane = ptr_q[LANE_W-1:0];
  assign at_eol    = eol_q;

  // next-state
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    desc_d   = desc_q;
    ctx_d    = ctx_q;
    next_d   = next_q;
    ptr_d    = ptr_q;
    after_d  = after_q;
    waddr_d  = waddr_q;
    flags_d  = flags_q;
    eop_d    = eop_q;
    close_d  = close_q;
    eol_d    = eol_q;
    pack_clr = 1'b0;
    set_intr = 1'b0;
    set_eop  = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        desc_d  = start_desc;
        ctx_d   = start_ctx;
        eol_d   = 1'b0;
        cnt_d   = '0;
        state_d = ST_FETCH;
      end
      ST_FETCH: if (xfer) begin
        cnt_d = cnt_q + CNT_W'(1);
        case (cnt_q)
          CNT_W'(W_NEXT):  next_d  = rd_addr;
          CNT_W'(W_BUF):   ptr_d   = rd_addr;
          CNT_W'(W_FLAGS): flags_d = m_rdata;
          default: begin
            after_d = rd_addr;
            eop_d   = 1'b0;
            state_d = (rd_addr == ptr_q) ? ST_WB_FLAGS : ST_STREAM;
          end
        endcase
      end
      ST_STREAM: if (accept) begin
        waddr_d = {ptr_q[AW-1:LANE_W], {LANE_W{1'b0}}};
        ptr_d   = ptr_inc;
        if (full || s_last || (&ptr_q[LANE_W-1:0])) begin
          state_d = ST_FLUSH;
          close_d = full | s_last;
          eop_d   = s_last;
        end
      end
      ST_FLUSH: if (xfer) begin
        pack_clr = 1'b1;
        state_d  = close_q ? ST_WB_FLAGS : ST_STREAM;
      end
      ST_WB_FLAGS: if (xfer) state_d = ST_WB_AFTER;
      ST_WB_AFTER: if (xfer) begin
        set_intr = flags_q[F_INTR];
        set_eop  = eop_q;
        if (flags_q[F_EOL]) begin
          state_d = ST_CTX;
        end else begin
          desc_d  = next_q;
          cnt_d   = '0;
          state_d = ST_FETCH;
        end
      end
      ST_CTX: if (xfer) begin
        eol_d   = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // memory request decode
  always_comb begin
    m_req   = 1'b1;
    m_we    = 1'b1;
    m_addr  = desc_q;
    m_wdata = '0;
    m_be    = '1;
    case (state_q)
      ST_FETCH: begin
        m_we   = 1'b0;
        m_addr = desc_q + (AW'(cnt_q) << LANE_W);
      end
      ST_FLUSH: begin
        m_addr  = waddr_q;
        m_wdata = pack_word;
        m_be    = pack_be;
      end
      ST_WB_FLAGS: begin
        m_addr  = desc_q + AW'(W_FLAGS * NBYTE);
        m_wdata = flags_q | (DW'(eop_q) << F_IN_EOP);
      end
      ST_WB_AFTER: begin
        m_addr  = desc_q + AW'(W_AFTER * NBYTE);
        m_wdata = DW'(ptr_q);
      end
      ST_CTX: begin
        m_addr  = ctx_q + AW'(CTX_FLAG_WORD * NBYTE);
        m_wdata = DW'(1) << CTX_DIS_BIT;
        m_be    = NBYTE'(1) << (CTX_DIS_BIT / 8);
      end
      default: begin
        m_req = 1'b0;
        m_we  = 1'b0;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      desc_q  <= '0;
      ctx_q   <= '0;
      next_q  <= '0;
      ptr_q   <= '0;
      after_q <= '0;
      waddr_q <= '0;
      flags_q <= '0;
      eop_q   <= 1'b0;
      close_q <= 1'b0;
      eol_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      desc_q  <= desc_d;
      ctx_q   <= ctx_d;
      next_q  <= next_d;
      ptr_q   <= ptr_d;
      after_q <= after_d;
      waddr_q <= waddr_d;
      flags_q <= flags_d;
      eop_q   <= eop_d;
      close_q <= close_d;
      eol_q   <= eol_d;
    end
  end
endmodule

// File: rtl/stream_dma_writer.sv
module stream_dma_writer
  import s2m_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    start_desc,
  input  logic [AW-1:0]    start_ctx,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  input  logic             s_last,
  output logic             s_ready,
  output logic             m_req,
  output logic             m_we,
  output logic [AW-1:0]    m_addr,
  output logic [DW-1:0]    m_wdata,
  output logic [NBYTE-1:0] m_be,
  input  logic             m_ack,
  input  logic [DW-1:0]    m_rdata,
  input  logic [IRQ_W-1:0] intr_mask,
  input  logic [IRQ_W-1:0] intr_clear,
  output logic [IRQ_W-1:0] intr_raw,
  output logic             irq,
  output logic             at_eol
);
  logic              pack_put, pack_clr, set_intr, set_eop;
  logic [LANE_W-1:0] pack_lane;
  logic [DW-1:0]     pack_word;
  logic [NBYTE-1:0]  pack_be;

  s2m_seq #(.AW(AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_desc (start_desc),
    .start_ctx  (start_ctx),
    .s_valid    (s_valid),
    .s_last     (s_last),
    .s_ready    (s_ready),
    .pack_put   (pack_put),
    .pack_lane  (pack_lane),
    .pack_clr   (pack_clr),
    .pack_word  (pack_word),
    .pack_be    (pack_be),
    .m_req      (m_req),
    .m_we       (m_we),
    .m_addr     (m_addr),
    .m_wdata    (m_wdata),
    .m_be       (m_be),
    .m_ack      (m_ack),
    .m_rdata    (m_rdata),
    .set_intr   (set_intr),
    .set_eop    (set_eop),
    .at_eol     (at_eol)
  );

  s2m_pack u_pack (
    .clk   (clk),
    .rst_n (rst_n),
    .put   (pack_put),
    .lane  (pack_lane),
    .din   (s_data),
    .clr   (pack_clr),
    .word  (pack_word),
    .be    (pack_be)
  );

  s2m_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_intr (set_intr),
    .set_eop  (set_eop),
    .clear    (intr_clear),
    .mask     (intr_mask),
    .raw      (intr_raw),
    .irq      (irq)
  );
endmodule

// File: rtl/stream_dma_writer_chk.sv
module stream_dma_writer_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_valid,
  input logic          s_last,
  input logic          s_ready,
  input logic          m_req,
  input logic          m_we,
  input logic [AW-1:0] m_addr,
  input logic [31:0]   m_wdata,
  input logic [3:0]    m_be,
  input logic          m_ack,
  input logic [3:0]    intr_clear,
  input logic [3:0]    intr_raw,
  input logic          at_eol
);
  p_quiet_during_mem_r10: assert property (@(posedge clk) disable iff (!rst_n)
    m_req |-> !s_ready);

  p_hold_request_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_be)));

  p_eol_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    at_eol |-> (!s_ready && !m_req));

  p_eol_after_ctx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(at_eol) |-> $past(m_req && m_ack && m_we && (m_be == 4'b0010) && m_wdata[15]));

  p_last_stalls_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && s_last) |=> !s_ready);

  p_raw_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(intr_raw) & ~intr_raw) != 4'b0) |->
      (($past(intr_raw) & ~intr_raw & ~$past(intr_clear)) == 4'b0));
endmodule

bind stream_dma_writer stream_dma_writer_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .s_valid    (s_valid),
  .s_last     (s_last),
  .s_ready    (s_ready),
  .m_req      (m_req),
  .m_we       (m_we),
  .m_addr     (m_addr),
  .m_wdata    (m_wdata),
  .m_be       (m_be),
  .m_ack      (m_ack),
  .intr_clear (intr_clear),
  .intr_raw   (intr_raw),
  .at_eol     (at_eol)
);

// File: tb/stream_dma_writer_test.sv
`timescale 1ns/1ps
module stream_dma_writer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_desc = '0, start_ctx = '0;
  logic        s_valid = 1'b0, s_last = 1'b0;
  logic [7:0]  s_data = '0;
  logic        s_ready, m_req, m_we, irq, at_eol;
  logic [31:0] m_addr, m_wdata;
  logic [3:0]  m_be, intr_raw;
  logic        m_ack = 1'b0;
  logic [31:0] m_rdata = '0;
  logic [3:0]  intr_mask = '0, intr_clear = '0;

  int checks = 0, errors = 0;
  int bad10 = 0, bad13 = 0;
  logic [7:0] mem_b [0:1023];
  logic [7:0] exp_b [0:1023];
  logic [7:0] sb [0:255];
  logic       sl [0:255];

  always #5 clk = ~clk;

  stream_dma_writer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_desc(start_desc),
    .start_ctx(start_ctx), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .s_ready(s_ready), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_be(m_be), .m_ack(m_ack), .m_rdata(m_rdata),
    .intr_mask(intr_mask), .intr_clear(intr_clear), .intr_raw(intr_raw),
    .irq(irq), .at_eol(at_eol)
  );

  // memory responder with random latency
  always @(posedge clk) begin
    m_ack <= 1'b0;
    if (rst_n && m_req && !m_ack && ($urandom_range(0, 2) != 0)) begin
      int base;
      base = int'({m_addr[9:2], 2'b00});
      m_ack <= 1'b1;
      if (m_we) begin
        for (int k = 0; k < 4; k++)
          if (m_be[k]) mem_b[base + k] = m_wdata[8*k +: 8];
      end else begin
        m_rdata <= {mem_b[base+3], mem_b[base+2], mem_b[base+1], mem_b[base]};
      end
    end
  end

  // protocol monitors (R10, R13)
  logic        pr_req = 1'b0, pr_ack = 1'b0, pr_we = 1'b0;
  logic [31:0] pr_addr = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_req && s_ready) bad10++;
      if (pr_req && !pr_ack && (!m_req || m_addr !== pr_addr || m_we !== pr_we)) bad13++;
    end
    pr_req = m_req; pr_ack = m_ack; pr_addr = m_addr; pr_we = m_we;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rdw(input int a);
    return {mem_b[a+3], mem_b[a+2], mem_b[a+1], mem_b[a]};
  endfunction
  function automatic logic [31:0] erdw(input int a);
    return {exp_b[a+3], exp_b[a+2], exp_b[a+1], exp_b[a]};
  endfunction
  task automatic ewrw(input int a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) exp_b[a+k] = v[8*k +: 8];
  endtask
  task automatic setw(input int a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) begin
      mem_b[a+k] = v[8*k +: 8];
      exp_b[a+k] = v[8*k +: 8];
    end
  endtask
  task automatic mk_desc(input int a, input int nx, input int bf, input int fl, input int af);
    setw(a, nx); setw(a + 4, bf); setw(a + 8, fl); setw(a + 12, af);
  endtask

  // reference model of the requirements
  task automatic run_model(input int first, input int ctx, output int used,
                           output logic [3:0] rexp);
    int d, p, nx, af, i;
    logic [31:0] fl;
    bit eop;
    d = first; i = 0; rexp = '0;
    forever begin
      nx = int'(erdw(d)); p = int'(erdw(d + 4)); fl = erdw(d + 8); af = int'(erdw(d + 12));
      eop = 1'b0;
      while (p != af && !eop) begin
        exp_b[p] = sb[i]; eop = sl[i]; p++; i++;
      end
      ewrw(d + 12, p);
      if (eop) fl = fl | 32'h800;
      ewrw(d + 8, fl);
      if (fl[4]) rexp = rexp | 4'b0011;
      if (eop) rexp = rexp | 4'b1000;
      if (fl[0]) begin exp_b[ctx + 5] = 8'h80; break; end
      d = nx;
    end
    used = i;
  endtask

  task automatic push(input logic [7:0] d, input logic last, input bit gaps);
    bit rdy;
    if (gaps && $urandom_range(0, 3) == 0) begin
      s_valid = 1'b0; @(negedge clk);
    end
    s_valid = 1'b1; s_data = d; s_last = last;
    forever begin
      rdy = s_ready;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic kick(input int d, input int c);
    start = 1'b1; start_desc = d; start_ctx = c;
    @(negedge clk);
    start = 1'b0;
    chk("R8 start clears at_eol", {31'b0, at_eol}, 32'd0);
  endtask

  task automatic wait_eol();
    for (int t = 0; t < 4000; t++) begin
      if (at_eol) break;
      @(negedge clk);
    end
    chk("R8 at_eol reached", {31'b0, at_eol}, 32'd1);
  endtask

  task automatic pulse_clear(input logic [3:0] v);
    intr_clear = v;
    @(negedge clk);
    intr_clear = '0;
  endtask

  task automatic cmp_image(input string tag);
    int mism, first;
    mism = 0; first = -1;
    for (int a = 0; a < 1024; a++)
      if (mem_b[a] !== exp_b[a]) begin
        mism++;
        if (first < 0) first = a;
      end
    if (mism != 0) $display("  first mismatch at %h: %h vs %h", first, mem_b[first], exp_b[first]);
    chk(tag, mism, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int used;
    logic [3:0] rexp;
    void'($urandom(32'd4711));
    for (int a = 0; a < 1024; a++) begin
      mem_b[a] = 8'(a) ^ 8'h5A;
      exp_b[a] = mem_b[a];
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset s_ready/m_req/irq/at_eol", {28'b0, s_ready, m_req, irq, at_eol}, 32'd0);
    chk("R1 reset intr_raw", {28'b0, intr_raw}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset idle", {29'b0, s_ready, m_req, at_eol}, 32'd0);

    // directed chain: fill, empty, early eop, fill+eol
    setw(12'h0F4, 32'h1234_0055);
    mk_desc(12'h000, 12'h010, 12'h201, 32'h10, 12'h207);
    mk_desc(12'h010, 12'h020, 12'h230, 32'h10, 12'h230);
    mk_desc(12'h020, 12'h030, 12'h241, 32'h00, 12'h250);
    mk_desc(12'h030, 12'h000, 12'h280, 32'h11, 12'h284);
    for (int i = 0; i < 6; i++)  begin sb[i] = 8'hA0 + 8'(i); sl[i] = 1'b0; end
    for (int i = 6; i < 11; i++) begin sb[i] = 8'hB0 + 8'(i); sl[i] = (i == 10); end
    for (int i = 11; i < 15; i++) begin sb[i] = 8'hC0 + 8'(i); sl[i] = 1'b0; end
    run_model(12'h000, 12'h0F0, used, rexp);
    chk("R7 model byte count", used, 15);
    kick(12'h000, 12'h0F0);
    for (int i = 0; i < used; i++) push(sb[i], sl[i], 1'b0);
    wait_eol();
    for (int i = 0; i < 6; i++) chk("R2 byte at buffer start + i", mem_b[12'h201 + i], sb[i]);
    chk("R3 byte before buffer kept", mem_b[12'h200], 8'h5A);
    chk("R3 byte at end address kept", mem_b[12'h207], 8'h07 ^ 8'h5A);
    chk("R3 byte after eop kept", mem_b[12'h246], 8'h46 ^ 8'h5A);
    chk("R4 filled after word", rdw(12'h00C), 32'h207);
    chk("R4 filled flags no eop", rdw(12'h008), 32'h10);
    chk("R12 empty after word", rdw(12'h01C), 32'h230);
    chk("R12 empty buffer untouched", mem_b[12'h230], 8'h30 ^ 8'h5A);
    chk("R5 eop after rewritten", rdw(12'h02C), 32'h246);
    chk("R5 eop flags bit 11", rdw(12'h028), 32'h800);
    chk("R7 next buffer filled", rdw(12'h280), {sb[14], sb[13], sb[12], sb[11]});
    chk("R8 context word disabled", rdw(12'h0F4), 32'h1234_8055);
    chk("R6 R5 raw interrupts", {28'b0, intr_raw}, {28'b0, rexp});
    cmp_image("R3 whole memory image");

    // R9 offered data at end of list
    begin
      int seen;
      seen = 0;
      s_valid = 1'b1; s_data = 8'hFF; s_last = 1'b1;
      for (int t = 0; t < 30; t++) begin
        @(negedge clk);
        if (s_ready || m_req) seen++;
      end
      s_valid = 1'b0; s_last = 1'b0;
      chk("R9 no ready/request at eol", seen, 0);
      cmp_image("R9 memory unchanged at eol");
    end

    // R11 interrupt mask and clear
    intr_mask = 4'b1000; #1;
    chk("R11 irq masked eop", {31'b0, irq}, 32'd1);
    pulse_clear(4'b1000);
    chk("R11 raw after clear", {28'b0, intr_raw}, 32'b0011);
    chk("R11 irq after clear", {31'b0, irq}, 32'd0);
    intr_mask = 4'b0001; #1;
    chk("R11 irq data bit", {31'b0, irq}, 32'd1);
    pulse_clear(4'b1111);
    chk("R11 raw cleared", {28'b0, intr_raw}, 32'd0);

    // constrained random chains
    for (int r = 0; r < 6; r++) begin
      for (int a = 0; a < 1024; a++) exp_b[a] = mem_b[a];
      for (int k = 0; k < 4; k++) begin
        int bf, ln;
        bf = 12'h300 + 32 * k + $urandom_range(0, 3);
        ln = $urandom_range(0, 12);
        mk_desc(12'h040 + 16 * k, 12'h040 + 16 * (k + 1), bf,
                (($urandom_range(0, 1)) << 4) | ((k == 3) ? 1 : 0), bf + ln);
      end
      setw(12'h0E4, $urandom());
      for (int i = 0; i < 256; i++) begin
        sb[i] = 8'($urandom());
        sl[i] = ($urandom_range(0, 3) == 0);
      end
      run_model(12'h040, 12'h0E0, used, rexp);
      kick(12'h040, 12'h0E0);
      for (int i = 0; i < used; i++) push(sb[i], sl[i], 1'b1);
      wait_eol();
      cmp_image("R7 R3 random chain image");
      chk("R6 random raw", {28'b0, intr_raw}, {28'b0, rexp});
      pulse_clear(4'b1111);
    end

    chk("R10 ready low during requests", bad10, 0);
    chk("R13 request held until ack", bad13, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule